// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits beside a USB dual-role controller and gathers its interrupt events behind a 32-bit register bus. Each bus access takes one cycle. Endpoint events arrive on two inputs: a transmit vector for endpoints 0 to 15 and a receive vector for endpoints 1 to 15. Core events arrive on a nine-bit vector. A separate level input reports whether the controller is driving the bus supply. All of these are captured into two independent interrupt groups, endpoint and core. Both groups drive a single interrupt output.

Each group holds three things: a sticky source register, a mask register, and a read-only masked view of the two. Software changes the source bits through a write-one-to-set alias and a write-one-to-clear alias, and the mask has the same pair of aliases. Because the set alias behaves exactly like a hardware event, software can fake an event, for instance a supply-drive change, to kick off its own polling. Once the output has fired, it stays quiet for new events until software writes the end-of-interrupt register. The block also provides a revision constant, a control register whose bit 0 holds the core in soft reset, a status register, and four plain configuration registers.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset, both groups' sources and masks are zero, the interrupt output is low, the output is armed, and reads of unused offsets (for example 0x10, 0x3C, 0x5C) return zero.
- R2: Offset 0x00 reads a nonzero revision constant.
- R3: Endpoint source (offset 0x20) places transmit event i at bit i (bits 15:0) and receive event for endpoint j at bit 16+j (bits 31:17); bit 16 always reads zero.
- R4: Core source (offset 0x40) places core event k at bit 16+k (bits 24:16); every other bit reads zero, even after a write of all ones to the set alias.
- R5: Source set (group base +0x04) and clear (base +0x08) aliases change only the bits written as one; when a hardware event and a clear hit the same bit in one cycle, the bit ends up set.
- R6: Mask register (base +0x0C) takes a full write, its set (base +0x10) and clear (base +0x14) aliases change only the bits written as one, and the masked view (base +0x18) reads source AND mask.
- R7: A source bit raised through the set alias raises the interrupt output exactly like a hardware event, when that bit is unmasked.
- R8: The registered interrupt output is high one cycle after either group has an unmasked source bit set, and it falls one cycle after all unmasked source bits are cleared.
- R9: Once the output has asserted, it does not assert again until a write of any value to offset 0x60; after that write, a pending unmasked source raises it on the next cycle.
- R10: Control bit 0 (offset 0x04) drives the soft-reset output and reads back.
- R11: Status bit 0 (offset 0x08) shows the supply-drive input after a two-flop synchronizer, and every change of the synchronized value sets core source bit 24.
- R12: Offsets 0x0C, 0x14, 0x18 and 0x1C are plain 32-bit registers that read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears on the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_evt | input | 16 | Transmit event pulses, endpoints 0..15 |
| rx_evt | input | 15 | Receive event pulses, endpoints 1..15 |
| core_evt | input | 9 | Core event pulses |
| vbus_drv | input | 1 | Asynchronous supply-drive level from the controller |
| core_soft_rst | output | 1 | Soft reset to the wrapped core |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench drives a clear and an event onto the same bit in the same cycle. A design that let the clear win would drop that bit and lose an event. It writes all ones into the set aliases and expects the unused bits, including endpoint bit 16, to stay zero; a leaky design would show stray bits that look like phantom endpoints. It also raises a second event while the output is disarmed. A design without the arm flag would fire again at once, and one that ignored the end-of-interrupt write would never fire again. Last, it toggles the supply-drive input and checks that the status bit follows and that core bit 24 is raised by the change rather than by the level.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int DW         = 32;
  localparam int AW         = 8;
  localparam int NUM_TX     = 16;
  localparam int NUM_RX     = 15;
  localparam int RX_LSB     = 17;
  localparam int NUM_CORE   = 9;
  localparam int CORE_LSB   = 16;
  localparam int NUM_GROUPS = 2;
  localparam int NUM_CFG    = 4;

  localparam logic [DW-1:0] EP_IMPL   = 32'hFFFE_FFFF;
  localparam logic [DW-1:0] CORE_IMPL = {{(DW-CORE_LSB-NUM_CORE){1'b0}}, {NUM_CORE{1'b1}}, {CORE_LSB{1'b0}}};

  localparam logic [AW-1:0] A_REV    = 8'h00;
  localparam logic [AW-1:0] A_CTRL   = 8'h04;
  localparam logic [AW-1:0] A_STAT   = 8'h08;
  localparam logic [AW-1:0] A_EOI    = 8'h60;
  localparam logic [AW-1:0] A_EPBASE = 8'h20;
  localparam logic [AW-1:0] A_COBASE = 8'h40;

  localparam logic [AW-1:0] G_SRC    = 8'h00;
  localparam logic [AW-1:0] G_SSET   = 8'h04;
  localparam logic [AW-1:0] G_SCLR   = 8'h08;
  localparam logic [AW-1:0] G_MSK    = 8'h0C;
  localparam logic [AW-1:0] G_MSET   = 8'h10;
  localparam logic [AW-1:0] G_MCLR   = 8'h14;
  localparam logic [AW-1:0] G_MASKED = 8'h18;

  // Plain configuration slots, index 0..3
  function automatic int cfg_slot(input logic [AW-1:0] a);
    case (a)
      8'h0C:   return 0;
      8'h14:   return 1;
      8'h18:   return 2;
      8'h1C:   return 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/usb_irq_group.sv
module usb_irq_group
  import usb_irq_pkg::*;
#(
  parameter int            W    = DW,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_evt,
  input  logic         src_set_we,
  input  logic         src_clr_we,
  input  logic         msk_we,
  input  logic         msk_set_we,
  input  logic         msk_clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] src,
  output logic [W-1:0] msk,
  output logic [W-1:0] masked
);
  logic [W-1:0] s_set, s_clr, m_set, m_clr;

  always_comb begin
    s_set = src_set_we ? wdata : '0;
    s_clr = src_clr_we ? wdata : '0;
    m_set = msk_set_we ? wdata : '0;
    m_clr = msk_clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      msk <= '0;
    end else begin
      // hardware events are ORed after the clear, so they win
      src <= ((src & ~s_clr) | s_set | hw_evt) & IMPL;
      if (msk_we) msk <= wdata & IMPL;
      else        msk <= ((msk & ~m_clr) | m_set) & IMPL;
    end
  end

  assign masked = src & msk;
endmodule

// File: rtl/usb_vbus_sync.sv
module usb_vbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic change
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      last <= sh[STAGES-1];
    end
  end

  assign level  = sh[STAGES-1];
  assign change = sh[STAGES-1] ^ last;
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID      = 32'h4D55_0102,
  parameter int            SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_TX-1:0]  tx_evt,
  input  logic [NUM_RX-1:0]  rx_evt,
  input  logic [NUM_CORE-1:0] core_evt,
  input  logic               vbus_drv,
  output logic               core_soft_rst,
  output logic               irq_out
);
  localparam logic [AW-1:0] GBASE [NUM_GROUPS] = '{A_EPBASE, A_COBASE};

  logic [DW-1:0] g_hw     [NUM_GROUPS];
  logic [DW-1:0] g_src    [NUM_GROUPS];
  logic [DW-1:0] g_msk    [NUM_GROUPS];
  logic [DW-1:0] g_masked [NUM_GROUPS];
  logic [DW-1:0] ep_src, ep_msk, core_src, core_msk;
  logic [DW-1:0] cfg_q [NUM_CFG];
  logic          vbus_lvl, vbus_chg;
  logic          ctrl_q, arm_q, pending, eoi_wr;

  usb_vbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(vbus_drv), .level(vbus_lvl), .change(vbus_chg)
  );

  always_comb begin
    g_hw[0] = '0;
    g_hw[0][NUM_TX-1:0]            = tx_evt;
    g_hw[0][RX_LSB+NUM_RX-1:RX_LSB] = rx_evt;
    g_hw[1] = '0;
    g_hw[1][CORE_LSB+NUM_CORE-1:CORE_LSB] = core_evt;
    g_hw[1][CORE_LSB+NUM_CORE-1]         = core_evt[NUM_CORE-1] | vbus_chg;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    usb_irq_group #(.W(DW), .IMPL(g == 0 ? EP_IMPL : CORE_IMPL)) u_grp (
      .clk       (clk),
      .rst       (rst),
      .hw_evt    (g_hw[g]),
      .src_set_we(bus_we && bus_addr == GBASE[g] + G_SSET),
      .src_clr_we(bus_we && bus_addr == GBASE[g] + G_SCLR),
      .msk_we    (bus_we && bus_addr == GBASE[g] + G_MSK),
      .msk_set_we(bus_we && bus_addr == GBASE[g] + G_MSET),
      .msk_clr_we(bus_we && bus_addr == GBASE[g] + G_MCLR),
      .wdata     (bus_wdata),
      .src       (g_src[g]),
      .msk       (g_msk[g]),
      .masked    (g_masked[g])
    );
  end

  assign ep_src   = g_src[0];
  assign ep_msk   = g_msk[0];
  assign core_src = g_src[1];
  assign core_msk = g_msk[1];

  // Control and plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[0];
      for (int i = 0; i < NUM_CFG; i++)
        if (cfg_slot(bus_addr) == i) cfg_q[i] <= bus_wdata;
    end
  end
  assign core_soft_rst = ctrl_q;

  // Interrupt output with end-of-interrupt arming
  assign pending = |(g_masked[0] | g_masked[1]);
  assign eoi_wr  = bus_we && bus_addr == A_EOI;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b1;
      irq_out <= 1'b0;
    end else begin
      irq_out <= pending & (arm_q | irq_out);
      if (eoi_wr)                arm_q <= 1'b1;
      else if (arm_q && pending) arm_q <= 1'b0;
    end
  end

  // Registered read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_REV:  rd_mux = REV_ID;
      A_CTRL: rd_mux = {{(DW-1){1'b0}}, ctrl_q};
      A_STAT: rd_mux = {{(DW-1){1'b0}}, vbus_lvl};
      default: begin
        for (int i = 0; i < NUM_CFG; i++)
          if (cfg_slot(bus_addr) == i) rd_mux = cfg_q[i];
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (bus_addr == GBASE[g] + G_SRC)    rd_mux = g_src[g];
          if (bus_addr == GBASE[g] + G_MSK)    rd_mux = g_msk[g];
          if (bus_addr == GBASE[g] + G_MASKED) rd_mux = g_masked[g];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
  import usb_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NUM_TX-1:0] tx_evt,
  input logic              irq_out,
  input logic              arm_q,
  input logic [DW-1:0]     ep_src,
  input logic [DW-1:0]     ep_msk,
  input logic [DW-1:0]     core_src,
  input logic [DW-1:0]     core_msk
);
  AST_EP_GAP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst) !ep_src[16] && !ep_msk[16]); // R3
  AST_CORE_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) ((core_src | core_msk) & ~CORE_IMPL) == '0); // R4
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_EPBASE + G_SCLR && bus_wdata[0] && tx_evt[0]) |=> ep_src[0]); // R5
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|((ep_src & ep_msk) | (core_src & core_msk)))); // R8
  AST_NO_REFIRE_UNARMED: assert property (@(posedge clk) disable iff (rst) $rose(irq_out) |-> $past(arm_q)); // R9
  AST_EOI_REARMS: assert property (@(posedge clk) disable iff (rst) (bus_we && bus_addr == A_EOI) |=> arm_q); // R9
endmodule

bind usb_irq_wrap usb_irq_wrap_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .tx_evt(tx_evt), .irq_out(irq_out), .arm_q(arm_q),
  .ep_src(ep_src), .ep_msk(ep_msk), .core_src(core_src), .core_msk(core_msk)
);

// File: tb/usb_irq_wrap_test.sv
module usb_irq_wrap_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tx_evt = '0;
  logic [14:0] rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b0;
  logic        core_soft_rst, irq_out;

  int n_chk = 0, n_fail = 0;
  int cycles = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  usb_irq_wrap uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .core_evt(core_evt), .vbus_drv(vbus_drv), .core_soft_rst(core_soft_rst), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0; v = bus_rdata;
  endtask

  task automatic cleanup();
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h60, 32'h0);
    tick(2);
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    rd(8'h20, d); check("R1 ep src", d, 0);
    rd(8'h2C, d); check("R1 ep mask", d, 0);
    rd(8'h40, d); check("R1 core src", d, 0);
    rd(8'h4C, d); check("R1 core mask", d, 0);
    rd(8'h10, d); check("R1 reserved 10", d, 0);
    rd(8'h3C, d); check("R1 reserved 3C", d, 0);
    rd(8'h5C, d); check("R1 reserved 5C", d, 0);
    rd(8'h00, d); n_chk++;
    if (d == 0) begin n_fail++; $display("FAIL R2: actual %h expected nonzero", d); end
  endtask

  task automatic t_ep_layout();
    tx_evt = 16'h8001; rx_evt = 15'h7FFF;
    tick(1);
    tx_evt = '0; rx_evt = '0;
    rd(8'h20, d); check("R3 ep layout", d, 32'hFFFE_8001);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R3 bit16 stays zero", d, 32'hFFFE_FFFF);
    cleanup();
  endtask

  task automatic t_core_layout();
    core_evt = 9'h101;
    tick(1);
    core_evt = '0;
    rd(8'h40, d); check("R4 core layout", d, 32'h0101_0000);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R4 unused bits zero", d, 32'h01FF_0000);
    cleanup();
  endtask

  task automatic t_alias();
    wr(8'h24, 32'h5); wr(8'h24, 32'h2);
    rd(8'h20, d); check("R5 set ones only", d, 32'h7);
    wr(8'h28, 32'h4);
    rd(8'h20, d); check("R5 clear ones only", d, 32'h3);
    tx_evt = 16'h0002; bus_addr = 8'h28; bus_wdata = 32'h2; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_evt = '0; bus_we = 1'b0;
    rd(8'h20, d); check("R5 event beats clear", d, 32'h3);
    cleanup();
  endtask

  task automatic t_mask();
    wr(8'h2C, 32'h0000_F0F0); wr(8'h30, 32'h1); wr(8'h34, 32'h10);
    rd(8'h2C, d); check("R6 mask aliases", d, 32'h0000_F0E1);
    wr(8'h24, 32'h0000_00FF);
    rd(8'h38, d); check("R6 masked view", d, 32'h0000_00E1);
    cleanup();
  endtask

  task automatic t_force_and_eoi();
    wr(8'h50, 32'h0100_0000);
    wr(8'h44, 32'h0100_0000);
    check("R8 not yet", {31'b0, irq_out}, 0);
    tick(1);
    check("R7 forced bit fires irq", {31'b0, irq_out}, 1);
    wr(8'h48, 32'h0100_0000);
    tick(1);
    check("R8 irq falls", {31'b0, irq_out}, 0);
    wr(8'h44, 32'h0100_0000);
    tick(3);
    check("R9 no refire before eoi", {31'b0, irq_out}, 0);
    wr(8'h60, 32'h0000_1234);
    tick(1);
    check("R9 fires after eoi", {31'b0, irq_out}, 1);
    cleanup();
    check("R8 low after cleanup", {31'b0, irq_out}, 0);
    wr(8'h30, 32'h0000_0008);
    tx_evt = 16'h0008; tick(1); tx_evt = '0;
    tick(1);
    check("R8 endpoint group drives irq", {31'b0, irq_out}, 1);
    cleanup();
  endtask

  task automatic t_ctrl();
    wr(8'h04, 32'h1);
    check("R10 soft reset out", {31'b0, core_soft_rst}, 1);
    rd(8'h04, d); check("R10 ctrl readback", d, 1);
    wr(8'h04, 32'h0);
    check("R10 soft reset released", {31'b0, core_soft_rst}, 0);
  endtask

  task automatic t_vbus();
    vbus_drv = 1'b1;
    tick(4);
    rd(8'h08, d); check("R11 status follows", d, 1);
    rd(8'h40, d); check("R11 change sets bit24", d, 32'h0100_0000);
    wr(8'h48, 32'h0100_0000);
    tick(3);
    rd(8'h40, d); check("R11 steady level no event", d, 0);
    vbus_drv = 1'b0;
    tick(4);
    rd(8'h08, d); check("R11 status low", d, 0);
    rd(8'h40, d); check("R11 fall sets bit24", d, 32'h0100_0000);
    cleanup();
  endtask

  task automatic t_cfg();
    wr(8'h0C, 32'hA5A5_0001); wr(8'h14, 32'h0000_0002);
    wr(8'h18, 32'h1234_5678); wr(8'h1C, 32'hFFFF_0000);
    rd(8'h0C, d); check("R12 cfg 0C", d, 32'hA5A5_0001);
    rd(8'h14, d); check("R12 cfg 14", d, 32'h0000_0002);
    rd(8'h18, d); check("R12 cfg 18", d, 32'h1234_5678);
    rd(8'h1C, d); check("R12 cfg 1C", d, 32'hFFFF_0000);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ep_layout();
    t_core_layout();
    t_alias();
    t_mask();
    t_force_and_eoi();
    t_ctrl();
    t_vbus();
    t_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule